// File: doc/BRIEF.md
# Serial Flash Status Register and Command Gate

This block holds the status state of a serial NOR flash target. It also decides, for each decoded command, whether the command may run. An upstream decoder presents one command strobe with a command class. The array engine reports the end of an operation, or a program or erase failure, with single-cycle pulses. The block answers each strobe with an accept or a reject pulse and keeps four status bits up to date: busy, write-enable latch, program error and erase error. It also presents those bits packed into a status byte that a status-read path can shift out.

The block enforces two rules. Program and erase require the write-enable latch to be set. After a failed program or erase, the block reports busy until recovery, and only a small set of commands is honoured. Recovery takes two steps, clear-status and write-disable, or a reset. While a normal operation is in progress, only status reads are honoured.

Top module: `flash_status_gate`

## Requirements
- R1: The status byte carries busy (WIP) at bit 0, write-enable latch (WEL) at bit 1, erase error at bit 5 and program error at bit 6. All other bits read 0.
- R2: While either error bit is set, WIP reads 1.
- R3: While an error bit is set, only these classes are accepted: status-read-1 (0), status-read-2 (1), write-disable (3), clear-status (4) and soft-reset (5). Any other class is rejected and leaves the status unchanged.
- R4: An accepted clear-status (class 4) clears WIP and both error bits and leaves WEL unchanged.
- R5: An accepted write-disable (class 3) clears WEL. Standby (status 0x00) after an error is reached only once both clear-status and write-disable have been applied.
- R6: A synchronous hardware reset (`rst`), or an accepted soft-reset (class 5), clears all four status bits.
- R7: Program (class 6) and erase (class 7) are rejected while WEL is 0, and the status is left unchanged.
- R8: An accepted write-enable (class 2) sets WEL. An engine done pulse during a fault-free operation clears both WIP and WEL.
- R9: Accepting a program or erase sets WIP on the same clock edge that raises the accept output.
- R10: While WIP is 1 with no error set, only classes 0 and 1 are accepted.
- R11: `cmd_accept` or `cmd_reject` pulses for exactly one cycle, on the cycle after each strobe. The two never pulse together, and neither pulses without a strobe.
- R12: A program-fail pulse during an operation sets the program-error bit, and an erase-fail pulse sets the erase-error bit. WIP stays 1 in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_class | input | 4 | Command class: 0 rd-status-1, 1 rd-status-2, 2 write-enable, 3 write-disable, 4 clear-status, 5 soft-reset, 6 program, 7 erase, others generic |
| eng_done | input | 1 | Array operation finished successfully |
| eng_prog_fail | input | 1 | Program operation failed |
| eng_erase_fail | input | 1 | Erase operation failed |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |
| p_err | output | 1 | Program error |
| e_err | output | 1 | Erase error |
| status_byte | output | 8 | Packed status |
| cmd_accept | output | 1 | Command accepted (one cycle after strobe) |
| cmd_reject | output | 1 | Command rejected (one cycle after strobe) |

## Verification
The gate is driven through a scripted session that walks every state: idle with the latch clear, idle with the latch set, a fault-free busy period, an erase-fault lockout and a program-fault lockout. The same command classes are offered in each state, so a wrong accept or reject shows which state's whitelist is at fault. Recovery is run both by clear-status followed by write-disable and by write-disable followed by clear-status. This separates a correct two-step recovery from one that returns to standby too early. Hardware reset is applied in the middle of a lockout, and cycles with no strobe confirm that no response appears without a command.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int CLASS_W = 4;
  localparam int STAT_W  = 8;
  localparam int WIP_BIT = 0;
  localparam int WEL_BIT = 1;
  localparam int EER_BIT = 5;
  localparam int PER_BIT = 6;

  typedef enum logic [CLASS_W-1:0] {
    CC_RDST1 = 4'd0,
    CC_RDST2 = 4'd1,
    CC_WREN  = 4'd2,
    CC_WRDI  = 4'd3,
    CC_CLRST = 4'd4,
    CC_SRST  = 4'd5,
    CC_PROG  = 4'd6,
    CC_ERASE = 4'd7
  } cmd_class_e;
endpackage

// File: rtl/fsg_cmd_filter.sv
module fsg_cmd_filter #(
  parameter int CLASS_W = 4,
  parameter logic [2**CLASS_W-1:0] ERR_MASK  = 16'h003B,
  parameter logic [2**CLASS_W-1:0] BUSY_MASK = 16'h0003
) (
  input  logic [CLASS_W-1:0] cls,
  input  logic               wip,
  input  logic               wel,
  input  logic               err,
  output logic               allow
);
  import fsg_pkg::*;
  logic needs_wel;

  always_comb begin
    needs_wel = (cls == CC_PROG) || (cls == CC_ERASE);
    if (err)
      allow = ERR_MASK[cls];
    else if (wip)
      allow = BUSY_MASK[cls];
    else
      allow = !needs_wel || wel;
  end
endmodule

// File: rtl/fsg_status_regs.sv
module fsg_status_regs #(
  parameter int CLASS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc,
  input  logic [CLASS_W-1:0] cls,
  input  logic               done,
  input  logic               pfail,
  input  logic               efail,
  output logic               wip,
  output logic               wel,
  output logic               p_err,
  output logic               e_err
);
  import fsg_pkg::*;
  logic running;

  assign running = wip && !p_err && !e_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      wip   <= 1'b0;
      wel   <= 1'b0;
      p_err <= 1'b0;
      e_err <= 1'b0;
    end else begin
      if (running) begin
        if (pfail || efail) begin
          p_err <= p_err | pfail;
          e_err <= e_err | efail;
        end else if (done) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end
      if (acc) begin
        case (cls)
          CC_WREN:  wel <= 1'b1;
          CC_WRDI:  wel <= 1'b0;
          CC_CLRST: begin
            wip   <= 1'b0;
            p_err <= 1'b0;
            e_err <= 1'b0;
          end
          CC_SRST: begin
            wip   <= 1'b0;
            wel   <= 1'b0;
            p_err <= 1'b0;
            e_err <= 1'b0;
          end
          CC_PROG, CC_ERASE: wip <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_status_gate.sv
module flash_status_gate #(
  parameter int CLASS_W = fsg_pkg::CLASS_W,
  parameter int STAT_W  = fsg_pkg::STAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [CLASS_W-1:0] cmd_class,
  input  logic               eng_done,
  input  logic               eng_prog_fail,
  input  logic               eng_erase_fail,
  output logic               wip,
  output logic               wel,
  output logic               p_err,
  output logic               e_err,
  output logic [STAT_W-1:0]  status_byte,
  output logic               cmd_accept,
  output logic               cmd_reject
);
  import fsg_pkg::*;

  logic allow;
  logic acc_now;

  fsg_cmd_filter #(.CLASS_W(CLASS_W)) filt_i (
    .cls   (cmd_class),
    .wip   (wip),
    .wel   (wel),
    .err   (p_err | e_err),
    .allow (allow)
  );

  assign acc_now = cmd_valid && allow;

  fsg_status_regs #(.CLASS_W(CLASS_W)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc_now),
    .cls   (cmd_class),
    .done  (eng_done),
    .pfail (eng_prog_fail),
    .efail (eng_erase_fail),
    .wip   (wip),
    .wel   (wel),
    .p_err (p_err),
    .e_err (e_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= acc_now;
      cmd_reject <= cmd_valid && !allow;
    end
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == WIP_BIT)      begin : g_wip assign status_byte[i] = wip;   end
    else if (i == WEL_BIT) begin : g_wel assign status_byte[i] = wel;   end
    else if (i == EER_BIT) begin : g_eer assign status_byte[i] = e_err; end
    else if (i == PER_BIT) begin : g_per assign status_byte[i] = p_err; end
    else                   begin : g_rsv assign status_byte[i] = 1'b0;  end
  end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int CLASS_W = 4,
  parameter int STAT_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [CLASS_W-1:0] cmd_class,
  input logic               wip,
  input logic               wel,
  input logic               p_err,
  input logic               e_err,
  input logic [STAT_W-1:0]  status_byte,
  input logic               cmd_accept,
  input logic               cmd_reject
);
  logic in_white;
  assign in_white = (cmd_class == 4'd0) || (cmd_class == 4'd1) || (cmd_class == 4'd3) ||
                    (cmd_class == 4'd4) || (cmd_class == 4'd5);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (status_byte & 8'h9C) == 8'h00);

  p_err_keeps_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (p_err || e_err) |-> wip);

  p_err_whitelist_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (p_err || e_err) && !in_white) |=> (cmd_reject && $stable(status_byte)));

  p_hw_reset_r6: assert property (@(posedge clk)
    rst |=> (!wip && !wel && !p_err && !e_err && !cmd_accept && !cmd_reject));

  p_need_wel_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wel && (cmd_class == 4'd6 || cmd_class == 4'd7)) |=> !cmd_accept);

  p_busy_reads_only_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && wip && !p_err && !e_err && cmd_class > 4'd1) |=> cmd_reject);

  p_one_response_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (cmd_accept ^ cmd_reject));

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!cmd_accept && !cmd_reject));
endmodule

bind flash_status_gate fsg_checker #(.CLASS_W(CLASS_W), .STAT_W(STAT_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
  .wip(wip), .wel(wel), .p_err(p_err), .e_err(e_err), .status_byte(status_byte),
  .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
);

// File: tb/flash_status_gate_tb_top.sv
module flash_status_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_class = 4'd0;
  logic       eng_done = 1'b0, eng_prog_fail = 1'b0, eng_erase_fail = 1'b0;
  logic       wip, wel, p_err, e_err, cmd_accept, cmd_reject;
  logic [7:0] status_byte;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  flash_status_gate dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .eng_done(eng_done), .eng_prog_fail(eng_prog_fail), .eng_erase_fail(eng_erase_fail),
    .wip(wip), .wel(wel), .p_err(p_err), .e_err(e_err), .status_byte(status_byte),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  // fields: valid, class[3:0], done, pfail, efail, resp[1:0] (0 none,1 acc,2 rej), status[7:0]
  function automatic logic [17:0] mk(input logic v, input logic [3:0] c, input logic [2:0] ev,
                                     input logic [1:0] rsp, input logic [7:0] st);
    return {v, c, ev, rsp, st};
  endfunction

  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    mk(1, 6, 3'b000, 2, 8'h00),  // R7 program without WEL
    mk(1, 7, 3'b000, 2, 8'h00),  // R7 erase without WEL
    mk(1, 2, 3'b000, 1, 8'h02),  // R8 WREN
    mk(1, 6, 3'b000, 1, 8'h03),  // R9 program sets WIP
    mk(1, 0, 3'b000, 1, 8'h03),  // R10 read ok while busy
    mk(1, 2, 3'b000, 2, 8'h03),  // R10 WREN rejected while busy
    mk(1, 4, 3'b000, 2, 8'h03),  // R10 clear-status rejected while busy
    mk(0, 0, 3'b100, 0, 8'h00),  // R8 done clears WIP and WEL
    mk(0, 0, 3'b000, 0, 8'h00),  // R11 no strobe
    mk(1, 2, 3'b000, 1, 8'h02),
    mk(1, 7, 3'b000, 1, 8'h03),  // R9 erase sets WIP
    mk(0, 0, 3'b001, 0, 8'h23),  // R12 erase fail
    mk(1, 6, 3'b000, 2, 8'h23),  // R3 program ignored
    mk(1, 2, 3'b000, 2, 8'h23),  // R3 WREN ignored
    mk(1, 8, 3'b000, 2, 8'h23),  // R3 generic ignored
    mk(1, 1, 3'b000, 1, 8'h23),  // R3 status read 2 ok
    mk(0, 0, 3'b100, 0, 8'h23),  // R2 done ignored while error
    mk(1, 4, 3'b000, 1, 8'h02),  // R4 clear-status, WEL kept
    mk(1, 3, 3'b000, 1, 8'h00),  // R5 write-disable -> standby
    mk(1, 2, 3'b000, 1, 8'h02),
    mk(1, 6, 3'b000, 1, 8'h03),
    mk(0, 0, 3'b010, 0, 8'h43),  // R12 program fail
    mk(1, 3, 3'b000, 1, 8'h41),  // R5 WRDI first, still busy
    mk(1, 8, 3'b000, 2, 8'h41),  // R3 generic ignored
    mk(1, 4, 3'b000, 1, 8'h00),  // R5 second step -> standby
    mk(1, 8, 3'b000, 1, 8'h00),  // generic accepted when idle
    mk(1, 2, 3'b000, 1, 8'h02),
    mk(1, 7, 3'b000, 1, 8'h03),
    mk(0, 0, 3'b001, 0, 8'h23),
    mk(1, 5, 3'b000, 1, 8'h00)   // R6 soft reset from error
  };

  task automatic chk(input string req, input logic [1:0] rsp, input logic [7:0] st);
    logic [1:0] got;
    got = {cmd_reject, cmd_accept};
    n_run++;
    if (got != rsp || status_byte != st ||
        wip != st[0] || wel != st[1] || e_err != st[5] || p_err != st[6]) begin
      n_fail++;
      $display("FAIL %s: resp=%0d status=%02h expected resp=%0d status=%02h",
               req, got, status_byte, rsp, st);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] c, input logic [2:0] ev);
    cmd_valid = v; cmd_class = c;
    {eng_done, eng_prog_fail, eng_erase_fail} = ev;
    @(negedge clk);
    cmd_valid = 1'b0;
    {eng_done, eng_prog_fail, eng_erase_fail} = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R6 reset state", 2'd0, 8'h00);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17], VEC[i][16:13], VEC[i][12:10]);
      chk($sformatf("R1/R11 vector %0d", i), VEC[i][9:8], VEC[i][7:0]);
    end
    // R6: hardware reset during an error lockout
    drive(1, 4'd2, 3'b000);
    drive(1, 4'd6, 3'b000);
    drive(0, 4'd0, 3'b010);
    chk("R12 setup before reset", 2'd0, 8'h43);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R6 hardware reset clears lockout", 2'd0, 8'h00);
    // R11: back-to-back strobes each answered once
    drive(1, 4'd2, 3'b000);
    chk("R11 first of pair", 2'd1, 8'h02);
    drive(1, 4'd3, 3'b000);
    chk("R11 second of pair", 2'd1, 8'h00);
    @(negedge clk);
    chk("R11 no response after strobe ends", 2'd0, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule